// File: doc/BRIEF.md
# Age-Ordered Floating-Point Issue Queue with Slow-Region Wakeup

This block is a scheduler for one floating-point execution port. Micro-ops are allocated with a destination tag, two source tags and the latency class of the op itself. Each entry watches a wakeup broadcast bus that carries a producer tag and that producer's latency class. When both of its sources are satisfied the entry may be selected. Each cycle, the oldest ready entry is sent to the issue output.

Age is tracked with a relation matrix, so an entry's age rank does not depend on the slot that holds it. When every slot is occupied, the `SLOW` oldest live entries form a slow region. An entry in that region that is woken by a single-cycle producer becomes ready one cycle later than usual. Other latency classes, fast-region entries and a queue that is not full see no added delay. Identical dependency chains can therefore issue at different cycles depending on how full the queue is.

Top module: `fpq_sched`

## Requirements
- R1: After synchronous reset, `alloc_ready` is 1 and `iss_valid` is 0.
- R2: Source tag 0 means no dependency. An op whose two source tags are both 0 appears on the issue output one cycle after the edge that allocates it.
- R3: When an entry is not in the slow region and its last outstanding source tag is broadcast at a clock edge, the entry appears on the issue output one cycle after that edge. This holds for every latency class. The latency class encoding is 0 = single-cycle, 1 = multi-cycle, 2 = load.
- R4: When the queue is full at the broadcast edge, an entry whose age rank is below `SLOW` (rank 0 = oldest) and that is woken with class 0 issues two cycles after that edge.
- R5: In that same full-queue slow-region case, a wakeup of class 1 or class 2 adds no delay (one cycle).
- R6: When the queue is not full, no entry gets the extra cycle, whatever its rank or the class of its wakeup.
- R7: Slow-region membership follows age rank among live entries, not slot index. A young entry placed in a recycled low slot is fast, and an entry of rank below `SLOW` sitting in a higher slot is slow.
- R8: An entry with two real sources does not issue until both tags have been broadcast.
- R9: At most one entry issues per cycle. When several entries are ready, the oldest issues first and the next one issues in the following cycle.
- R10: While all slots are occupied, `alloc_ready` is 0 and `alloc_valid` is ignored: the offered op is neither stored nor issued.
- R11: An allocation and an issue may share a clock edge. A slot freed by an issue can take a new allocation at the following edge.
- R12: A wakeup broadcast in the same cycle that an op is allocated satisfies the matching source of that op.
- R13: `iss_tag` and `iss_lat` carry the destination tag and latency class given at allocation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Allocation request |
| alloc_tag | input | TAG_W | Destination tag of the new op |
| alloc_src0 | input | TAG_W | First source tag (0 = none) |
| alloc_src1 | input | TAG_W | Second source tag (0 = none) |
| alloc_lat | input | 2 | Latency class of the new op |
| alloc_ready | output | 1 | Low while all slots are occupied |
| wk_valid | input | 1 | Wakeup broadcast valid |
| wk_tag | input | TAG_W | Tag of the producer being broadcast |
| wk_lat | input | 2 | Latency class of that producer |
| iss_valid | output | 1 | Registered issue strobe |
| iss_tag | output | TAG_W | Destination tag of the issued op |
| iss_lat | output | 2 | Latency class of the issued op |

## Verification
Several properties are checked on every cycle by the assertions. They cover: one issue at most per cycle; no more than `SLOW` entries marked slow at a time; a pending wakeup always turning into readiness one cycle later; a pending bit appearing only when a class 0 wakeup hits a slow entry of a full queue; a granted entry having both sources ready; and a full queue staying unchanged when nothing issues. The exact issue cycle cannot be seen from any single cycle. This includes the one-cycle versus two-cycle split across rank, fullness and class, the rank-versus-slot distinction after slots are recycled, and the oldest-first order. The bench's scenarios show these, including a sweep over every rank and class with the queue full and one entry short of full.

// File: rtl/fpq_pkg.sv
package fpq_pkg;
  typedef enum logic [1:0] {
    LAT_SINGLE = 2'd0,
    LAT_MULTI  = 2'd1,
    LAT_LOAD   = 2'd2
  } lat_e;
endpackage

// File: rtl/fpq_slot.sv
// One scheduler entry: destination, two watched sources, readiness and
// the one-cycle pending flag used for delayed slow-region wakeups.
module fpq_slot
  import fpq_pkg::*;
#(
  parameter int TAG_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc_we,
  input  logic [TAG_W-1:0] alloc_tag,
  input  logic [TAG_W-1:0] alloc_src0,
  input  logic [TAG_W-1:0] alloc_src1,
  input  lat_e             alloc_lat,
  input  logic             wk_valid,
  input  logic [TAG_W-1:0] wk_tag,
  input  lat_e             wk_lat,
  input  logic             q_full,
  input  logic             is_slow,
  input  logic             grant,
  output logic             busy,
  output logic             req,
  output logic [TAG_W-1:0] dst,
  output lat_e             lat
);
  logic [TAG_W-1:0] src     [2];
  logic [TAG_W-1:0] new_src [2];
  logic [1:0]       rdy;
  logic [1:0]       pend;
  logic [1:0]       hit;
  logic             hold;

  always_comb begin
    new_src[0] = alloc_src0;
    new_src[1] = alloc_src1;
    hold = q_full && is_slow && (wk_lat == LAT_SINGLE);
    for (int k = 0; k < 2; k++)
      hit[k] = wk_valid && (wk_tag == src[k]) && !rdy[k] && !pend[k];
  end

  assign req = busy && (&rdy);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      rdy  <= 2'b00;
      pend <= 2'b00;
      dst  <= '0;
      lat  <= LAT_SINGLE;
      for (int k = 0; k < 2; k++) src[k] <= '0;
    end else if (alloc_we) begin
      busy <= 1'b1;
      dst  <= alloc_tag;
      lat  <= alloc_lat;
      for (int k = 0; k < 2; k++) begin
        src[k]  <= new_src[k];
        rdy[k]  <= (new_src[k] == '0) || (wk_valid && (wk_tag == new_src[k]));
        pend[k] <= 1'b0;
      end
    end else if (grant) begin
      busy <= 1'b0;
      rdy  <= 2'b00;
      pend <= 2'b00;
    end else begin
      for (int k = 0; k < 2; k++) begin
        if (pend[k]) begin
          rdy[k]  <= 1'b1;
          pend[k] <= 1'b0;
        end else if (busy && hit[k]) begin
          if (hold) pend[k] <= 1'b1;
          else      rdy[k]  <= 1'b1;
        end
      end
    end
  end

  AST_PEND0_RESOLVES: assert property (@(posedge clk) disable iff (rst)
    (busy && pend[0]) |=> rdy[0]); // R4
  AST_PEND1_RESOLVES: assert property (@(posedge clk) disable iff (rst)
    (busy && pend[1]) |=> rdy[1]); // R4
  AST_PEND_NEEDS_FULL: assert property (@(posedge clk) disable iff (rst)
    ($rose(pend[0]) || $rose(pend[1])) |-> $past(q_full && is_slow && (wk_lat == LAT_SINGLE))); // R6
  AST_GRANT_READY: assert property (@(posedge clk) disable iff (rst)
    grant |-> (busy && (&rdy))); // R8
endmodule

// File: rtl/fpq_age.sv
// Age relation matrix: row i holds a bit for every slot that is older than i.
// Produces the rank-based slow flags and the oldest-ready pick.
module fpq_age #(
  parameter int DEPTH = 16,
  parameter int SLOW  = 4,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DEPTH-1:0] busy,
  input  logic [DEPTH-1:0] req,
  input  logic             alloc_we,
  input  logic [IDX_W-1:0] alloc_slot,
  output logic [DEPTH-1:0] pick,
  output logic [DEPTH-1:0] slow
);
  logic [DEPTH-1:0] older [DEPTH];

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      slow[i] = busy[i] && ($countones(busy & older[i]) < SLOW);
      pick[i] = req[i] && ((req & older[i]) == '0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) older[i] <= '0;
    end else if (alloc_we) begin
      for (int i = 0; i < DEPTH; i++) older[i][alloc_slot] <= 1'b0;
      older[alloc_slot] <= busy & ~pick;
    end
  end

  AST_ONE_ISSUE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pick)); // R9
  AST_SLOW_BOUND: assert property (@(posedge clk) disable iff (rst)
    $countones(slow) <= SLOW); // R7
endmodule

// File: rtl/fpq_sched.sv
module fpq_sched
  import fpq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int SLOW  = 4,
  parameter int TAG_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc_valid,
  input  logic [TAG_W-1:0] alloc_tag,
  input  logic [TAG_W-1:0] alloc_src0,
  input  logic [TAG_W-1:0] alloc_src1,
  input  logic [1:0]       alloc_lat,
  output logic             alloc_ready,
  input  logic             wk_valid,
  input  logic [TAG_W-1:0] wk_tag,
  input  logic [1:0]       wk_lat,
  output logic             iss_valid,
  output logic [TAG_W-1:0] iss_tag,
  output logic [1:0]       iss_lat
);
  localparam int IDX_W = $clog2(DEPTH);

  logic [DEPTH-1:0] busy, req, pick, slow;
  logic [TAG_W-1:0] slot_dst [DEPTH];
  lat_e             slot_lat [DEPTH];
  logic             full, do_alloc;
  logic [IDX_W-1:0] free_idx;
  logic [TAG_W-1:0] sel_tag;
  logic [1:0]       sel_lat;

  assign full        = &busy;
  assign alloc_ready = !full;
  assign do_alloc    = alloc_valid && !full;

  always_comb begin
    free_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (!busy[i]) free_idx = IDX_W'(i);
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    fpq_slot #(.TAG_W(TAG_W)) u_slot (
      .clk        (clk),
      .rst        (rst),
      .alloc_we   (do_alloc && (free_idx == IDX_W'(g))),
      .alloc_tag  (alloc_tag),
      .alloc_src0 (alloc_src0),
      .alloc_src1 (alloc_src1),
      .alloc_lat  (lat_e'(alloc_lat)),
      .wk_valid   (wk_valid),
      .wk_tag     (wk_tag),
      .wk_lat     (lat_e'(wk_lat)),
      .q_full     (full),
      .is_slow    (slow[g]),
      .grant      (pick[g]),
      .busy       (busy[g]),
      .req        (req[g]),
      .dst        (slot_dst[g]),
      .lat        (slot_lat[g])
    );
  end

  fpq_age #(.DEPTH(DEPTH), .SLOW(SLOW), .IDX_W(IDX_W)) u_age (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .req        (req),
    .alloc_we   (do_alloc),
    .alloc_slot (free_idx),
    .pick       (pick),
    .slow       (slow)
  );

  always_comb begin
    sel_tag = '0;
    sel_lat = '0;
    for (int i = 0; i < DEPTH; i++) begin
      sel_tag = sel_tag | ({TAG_W{pick[i]}} & slot_dst[i]);
      sel_lat = sel_lat | ({2{pick[i]}} & slot_lat[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      iss_valid <= 1'b0;
      iss_tag   <= '0;
      iss_lat   <= '0;
    end else begin
      iss_valid <= |pick;
      iss_tag   <= sel_tag;
      iss_lat   <= sel_lat;
    end
  end

  AST_NO_ALLOC_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
    (full && (pick == '0)) |=> (full && $stable(busy))); // R10
endmodule

// File: tb/fpq_sched_bench.sv
`timescale 1ns/1ps
module fpq_sched_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       alloc_valid = 1'b0;
  logic [5:0] alloc_tag = '0, alloc_src0 = '0, alloc_src1 = '0;
  logic [1:0] alloc_lat = '0;
  logic       alloc_ready;
  logic       wk_valid = 1'b0;
  logic [5:0] wk_tag = '0;
  logic [1:0] wk_lat = '0;
  logic       iss_valid;
  logic [5:0] iss_tag;
  logic [1:0] iss_lat;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  fpq_sched #(.DEPTH(16), .SLOW(4), .TAG_W(6)) u_fpq_sched (
    .clk(clk), .rst(rst),
    .alloc_valid(alloc_valid), .alloc_tag(alloc_tag), .alloc_src0(alloc_src0),
    .alloc_src1(alloc_src1), .alloc_lat(alloc_lat), .alloc_ready(alloc_ready),
    .wk_valid(wk_valid), .wk_tag(wk_tag), .wk_lat(wk_lat),
    .iss_valid(iss_valid), .iss_tag(iss_tag), .iss_lat(iss_lat)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    tick();
    tick();
    rst = 1'b0;
    tick();
  endtask

  task automatic alloc(input int t, input int s0, input int s1, input int l);
    alloc_valid = 1'b1;
    alloc_tag   = 6'(t);
    alloc_src0  = 6'(s0);
    alloc_src1  = 6'(s1);
    alloc_lat   = 2'(l);
    tick();
    alloc_valid = 1'b0;
  endtask

  task automatic wake(input int t, input int l);
    wk_valid = 1'b1;
    wk_tag   = 6'(t);
    wk_lat   = 2'(l);
    tick();
    wk_valid = 1'b0;
  endtask

  // cycles after the last edge until the given tag shows on the issue output
  task automatic wait_issue(input int t, output int n);
    n = 0;
    while (!(iss_valid && iss_tag == 6'(t)) && n < 10) begin
      tick();
      n++;
    end
  endtask

  task automatic fill(input int n);
    for (int i = 0; i < n; i++) alloc(1 + i, 17 + i, 0, i % 3);
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    report();
  end

  initial begin
    int d;
    int exp;
    bit quiet;

    // R1 reset state
    do_reset();
    check(alloc_ready == 1'b1, "R1 alloc_ready", alloc_ready, 1);
    check(iss_valid == 1'b0, "R1 iss_valid", iss_valid, 0);

    // R2 op with no dependency
    alloc(33, 0, 0, 2);
    wait_issue(33, d);
    check(d == 1, "R2 no-dependency issue delay", d, 1);
    check(iss_lat == 2'd2, "R13 iss_lat", iss_lat, 2);

    // Sweep: fullness x rank x class (R3, R4, R5, R6)
    for (int full = 0; full < 2; full++) begin
      for (int r = 0; r < (full ? 16 : 15); r++) begin
        for (int l = 0; l < 3; l++) begin
          do_reset();
          fill(full ? 16 : 15);
          wake(17 + r, l);
          wait_issue(1 + r, d);
          exp = (full == 1 && r < 4 && l == 0) ? 2 : 1;
          if (full == 0)      check(d == exp, "R6 not-full delay", d, exp);
          else if (r >= 4)    check(d == exp, "R3 fast-region delay", d, exp);
          else if (l == 0)    check(d == exp, "R4 slow single-cycle delay", d, exp);
          else                check(d == exp, "R5 slow long-class delay", d, exp);
        end
      end
    end

    // R7 rank, not slot index
    do_reset();
    fill(16);
    wake(17, 1);
    wait_issue(1, d);
    check(d == 1, "R5 rank0 multi-cycle", d, 1);
    alloc(40, 50, 0, 0);               // recycled slot 0, youngest
    wake(50, 0);
    wait_issue(40, d);
    check(d == 1, "R7 young entry in low slot is fast", d, 1);
    alloc(41, 51, 0, 0);               // full again
    wake(21, 0);                       // tag 5, slot 4, rank 3
    wait_issue(5, d);
    check(d == 2, "R7 rank3 entry in slot 4 is slow", d, 2);

    // R8 two sources
    do_reset();
    alloc(32, 61, 62, 2);
    wake(61, 0);
    quiet = 1'b1;
    for (int i = 0; i < 3; i++) begin
      if (iss_valid) quiet = 1'b0;
      tick();
    end
    check(quiet, "R8 no issue with one source pending", int'(quiet), 1);
    wake(62, 0);
    wait_issue(32, d);
    check(d == 1, "R8 issue after second source", d, 1);

    // R9 oldest first, one per cycle; R13 fields
    do_reset();
    alloc(30, 60, 0, 0);
    alloc(31, 60, 0, 1);
    wake(60, 1);
    tick();
    check(iss_valid && iss_tag == 6'd30, "R9 oldest first", iss_tag, 30);
    check(iss_lat == 2'd0, "R13 iss_lat first", iss_lat, 0);
    tick();
    check(iss_valid && iss_tag == 6'd31, "R9 younger next cycle", iss_tag, 31);
    check(iss_lat == 2'd1, "R13 iss_lat second", iss_lat, 1);

    // R10 stall while full
    do_reset();
    fill(16);
    check(alloc_ready == 1'b0, "R10 alloc_ready low when full", alloc_ready, 0);
    alloc(35, 0, 0, 0);
    quiet = 1'b1;
    for (int i = 0; i < 4; i++) begin
      if (iss_valid) quiet = 1'b0;
      tick();
    end
    check(quiet, "R10 stalled op not issued", int'(quiet), 1);
    wake(17, 0);
    wait_issue(1, d);
    check(d == 2, "R4 rank0 single-cycle when full", d, 2);
    check(alloc_ready == 1'b1, "R10 alloc_ready after issue", alloc_ready, 1);

    // R11 alloc and issue on one edge, freed slot reused
    do_reset();
    fill(15);
    wake(17, 1);
    alloc(36, 52, 0, 0);               // same edge as tag 1 issues
    check(iss_valid && iss_tag == 6'd1, "R11 issue on shared edge", iss_tag, 1);
    check(alloc_ready == 1'b1, "R11 count unchanged", alloc_ready, 1);
    alloc(37, 53, 0, 0);               // takes the freed slot
    check(alloc_ready == 1'b0, "R11 freed slot reused", alloc_ready, 0);

    // R12 wakeup in the allocation cycle
    do_reset();
    wk_valid = 1'b1;
    wk_tag   = 6'd63;
    wk_lat   = 2'd0;
    alloc(34, 63, 0, 0);
    wk_valid = 1'b0;
    wait_issue(34, d);
    check(d == 1, "R12 same-cycle wakeup", d, 1);

    report();
  end
endmodule